// File: doc/BRIEF.md
# Serial-Addressed Sequential-Read Front End

This block sits in front of a three-bank, one-bit-wide storage array and turns a slow, strobe-driven host protocol into array read requests. The host gives a start address as two 10-bit halves. Each half is shifted in serially on its own data line and is clocked by its own strobe. A separate transfer strobe then copies both halves into a 20-bit address counter. After that, each falling edge of a read clock fetches one bit from the array at the counter's address and moves the counter on by one, so a long run of bits streams out with no further addressing.

Three active-low selects choose the bank. While no select is low the block ignores every host strobe and keeps its output disabled. All host signals are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the strobes are converted to one-cycle pulses inside the block. The array is outside the block: it takes a read pulse, a bank index and a word address, and it returns the data bit one clock later. The output bit comes with a drive enable, which is high only while a bank is selected and the read clock is low.

Top module: `seqrd_front`

## Requirements
- R1: The X half enters least-significant bit first. The bit on `sx_dat` is captured on each rising edge of `sx_strb`. After a transfer, the last ten captured X bits appear on `mem_addr[9:0]`.
- R2: The Y half is captured the same way from `sy_dat` on rising edges of `sy_strb`, and it appears on `mem_addr[19:10]` after a transfer. A Y half that is not reloaded keeps its previous contents.
- R3: Each serial register keeps only the most recent ten bits. When more than ten bits are sent, the earlier bits are dropped.
- R4: A falling edge of `xfer_strb` loads both serial registers into the address counter. The counter drives `mem_addr`, and the new value is present there no more than four system clocks after the edge.
- R5: A falling edge of `rd_clk` issues one `mem_rd` pulse at the current address and then increments the counter by one. A carry out of the low ten bits increments the high ten bits.
- R6: The counter wraps from 20'hFFFFF to 20'h00000.
- R7: Two system clocks after the inputs change, `dout_en` is low whenever `rd_clk` is high or all three selects are high. While the read clock stays low, `dout` holds the bit last read.
- R8: Within four system clocks of a falling `rd_clk`, `dout` equals the array bit at the bank and address that were presented with that read request.
- R9: `sel_n[0]`, `sel_n[1]` and `sel_n[2]` select banks 1, 2 and 3, which appear on `mem_bank` as 0, 1 and 2. When several selects are low, the lowest-numbered bank wins.
- R10: While all selects are high, serial strobes, transfer strobes and read clock edges change neither the serial registers nor the counter.
- R11: Changing the selects does not alter the address counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sx_dat | input | 1 | Serial data for the X half |
| sx_strb | input | 1 | X capture strobe, rising edge active |
| sy_dat | input | 1 | Serial data for the Y half |
| sy_strb | input | 1 | Y capture strobe, rising edge active |
| xfer_strb | input | 1 | Transfer strobe, falling edge loads the counter |
| rd_clk | input | 1 | Read clock, falling edge reads and advances |
| sel_n | input | 3 | Active-low bank selects |
| mem_rd | output | 1 | One-cycle read request to the array |
| mem_bank | output | 2 | Bank index for the array |
| mem_addr | output | 20 | Word address for the array (counter value) |
| mem_rdata | input | 1 | Array data, valid the clock after `mem_rd` |
| dout | output | 1 | Read data bit |
| dout_en | output | 1 | Output drive enable |

## Verification
The hardest situation to reach from the ports is the counter carrying across both halves at once: the low half rolls into the high half, and the all-ones value wraps to zero. Stepping there one read at a time would take about a million reads. The bench reaches it directly by shifting all-ones start halves and transferring them, so only a single read is needed. The other hard case is stimulus sent while no bank is selected, because the address counter is not visible from the ports until a bank is selected again. The bench re-enables a bank after the ignored strobes, compares `mem_addr` and the next read bit against its model, and then runs a transfer. That transfer exposes serial registers which must still hold the values shifted before the deselect.

// File: rtl/seqrd_pkg.sv
// Package: shared widths and the bank-priority decode for the sequential-read
// front end. Assumes bank 1 is the highest priority select.
package seqrd_pkg;
    localparam int XW     = 10;
    localparam int YW     = 10;
    localparam int NBANK  = 3;
    localparam int BANKW  = $clog2(NBANK);
    localparam int ADDRW  = XW + YW;

    typedef logic [BANKW-1:0] bank_t;

    // Lowest-numbered low select wins; index 0 when none is low.
    function automatic bank_t bank_pick(input logic [NBANK-1:0] sel_n);
        bank_t b;
        b = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (!sel_n[i]) b = bank_t'(i);
        end
        return b;
    endfunction
endpackage

// File: rtl/seqrd_sync.sv
// Module: two-flop level synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; reset value is given per bit.
module seqrd_sync #(
    parameter int           W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl
);
    logic [W-1:0] meta;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST;
            lvl  <= RST;
        end else begin
            meta <= din;
            lvl  <= meta;
        end
    end
endmodule

// File: rtl/seqrd_edge.sv
// Module: turns synchronized levels into one-cycle pulses. FALL_MASK picks,
// per bit, a falling-edge (1) or rising-edge (0) detector.
module seqrd_edge #(
    parameter int           W         = 1,
    parameter logic [W-1:0] RST       = '0,
    parameter logic [W-1:0] FALL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] pulse
);
    logic [W-1:0] prev;

    // Remember last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST;
        else        prev <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_det
        if (FALL_MASK[i]) begin : g_fall
            assign pulse[i] = prev[i] & ~lvl[i];
        end else begin : g_rise
            assign pulse[i] = ~prev[i] & lvl[i];
        end
    end
endmodule

// File: rtl/seqrd_shift.sv
// Module: serial address register, LSB received first, right-shifting.
// Assumes en is a one-cycle pulse aligned with a synchronized data bit.
module seqrd_shift #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    // Shift a new bit into the top; oldest bit falls off bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {din, q[W-1:1]};
    end

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
    assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (q[W-1] == $past(din)) && (q[W-2:0] == $past(q[W-1:1])));
endmodule

// File: rtl/seqrd_counter.sv
// Module: split X/Y address counter. X is the low half, its carry feeds Y,
// and the whole value wraps to zero. A load takes priority over an increment.
module seqrd_counter #(
    parameter int XW = 10,
    parameter int YW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [XW-1:0] load_x,
    input  logic [YW-1:0] load_y,
    input  logic          inc,
    output logic [XW-1:0] cnt_x,
    output logic [YW-1:0] cnt_y
);
    localparam logic [XW-1:0] XMAX = '1;
    localparam logic [YW-1:0] YMAX = '1;

    logic x_carry;
    assign x_carry = (cnt_x == XMAX);

    // Load start address, or step X and ripple its carry into Y.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_x <= '0;
            cnt_y <= '0;
        end else if (load) begin
            cnt_x <= load_x;
            cnt_y <= load_y;
        end else if (inc) begin
            cnt_x <= cnt_x + 1'b1;
            if (x_carry) cnt_y <= cnt_y + 1'b1;
        end
    end

    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_x == $past(load_x)) && (cnt_y == $past(load_y)));
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> {cnt_y, cnt_x} == $past({cnt_y, cnt_x}) + 1'b1);
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && cnt_x == XMAX && cnt_y == YMAX) |=> (cnt_x == '0) && (cnt_y == '0));
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable({cnt_y, cnt_x}));
endmodule

// File: rtl/seqrd_front.sv
// Module: top of the serial-addressed sequential-read front end.
// Synchronizes host strobes, collects the two serial address halves, runs the
// address counter, decodes the bank and gates the registered output bit.
// Assumes the array returns mem_rdata one clock after mem_rd.
module seqrd_front
    import seqrd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sx_dat,
    input  logic             sx_strb,
    input  logic             sy_dat,
    input  logic             sy_strb,
    input  logic             xfer_strb,
    input  logic             rd_clk,
    input  logic [NBANK-1:0] sel_n,
    output logic             mem_rd,
    output logic [BANKW-1:0] mem_bank,
    output logic [ADDRW-1:0] mem_addr,
    input  logic             mem_rdata,
    output logic             dout,
    output logic             dout_en
);
    localparam int NLVL = NBANK + 6;
    localparam logic [NLVL-1:0] LVL_RST = {{NBANK{1'b1}}, 4'b1111, 2'b00};

    logic [NLVL-1:0] raw, lvl;
    logic [3:0]      pulses;
    logic [NBANK-1:0] sel_s;
    logic active, sx_p, sy_p, xf_p, rd_p;
    logic [XW-1:0] sreg_x, cnt_x;
    logic [YW-1:0] sreg_y, cnt_y;
    logic rd_pend, dout_q;

    assign raw = {sel_n, rd_clk, xfer_strb, sy_strb, sx_strb, sy_dat, sx_dat};

    seqrd_sync #(.W(NLVL), .RST(LVL_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw), .lvl(lvl));

    seqrd_edge #(.W(4), .RST(4'b1111), .FALL_MASK(4'b1100)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl[5:2]), .pulse(pulses));

    assign sel_s  = lvl[NLVL-1:6];
    assign active = ~&sel_s;
    assign sx_p   = pulses[0] & active;
    assign sy_p   = pulses[1] & active;
    assign xf_p   = pulses[2] & active;
    assign rd_p   = pulses[3] & active;

    seqrd_shift #(.W(XW)) u_sx (
        .clk(clk), .rst_n(rst_n), .en(sx_p), .din(lvl[0]), .q(sreg_x));
    seqrd_shift #(.W(YW)) u_sy (
        .clk(clk), .rst_n(rst_n), .en(sy_p), .din(lvl[1]), .q(sreg_y));

    seqrd_counter #(.XW(XW), .YW(YW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(xf_p), .load_x(sreg_x), .load_y(sreg_y),
        .inc(rd_p), .cnt_x(cnt_x), .cnt_y(cnt_y));

    assign mem_rd   = rd_p;
    assign mem_addr = {cnt_y, cnt_x};
    assign mem_bank = bank_pick(sel_s);

    // Track the read in flight and register the returned bit a clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            dout_q  <= 1'b0;
        end else begin
            rd_pend <= mem_rd;
            if (rd_pend) dout_q <= mem_rdata;
        end
    end

    assign dout    = dout_q;
    assign dout_en = active & ~lvl[5];

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_pend |=> $stable(dout_q));
    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pend |=> dout_q == $past(mem_rdata));
    assert_bank_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_bank < BANKW'(NBANK));
    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&sel_s) |=> $stable(mem_addr));
endmodule

// File: tb/sim_seqrd_front.sv
// Bench: behavioural model of the front end with a computed array, checked
// at settled points and on every clock for the output enable.
module sim_seqrd_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sx_dat = 0, sx_strb = 1, sy_dat = 0, sy_strb = 1, xfer_strb = 1, rd_clk = 1;
    logic [2:0] sel_n = 3'b111;
    logic mem_rd, mem_rdata = 1'b0, dout, dout_en;
    logic [1:0] mem_bank;
    logic [19:0] mem_addr;

    int checks = 0, errors = 0;
    int model_addr = 0;
    int cur_bank = 0;
    logic [3:0] h1 = 4'hF, h2 = 4'hF;
    int settle = 0;

    always #4 clk = ~clk;

    seqrd_front u0 (
        .clk(clk), .rst_n(rst_n), .sx_dat(sx_dat), .sx_strb(sx_strb),
        .sy_dat(sy_dat), .sy_strb(sy_strb), .xfer_strb(xfer_strb), .rd_clk(rd_clk),
        .sel_n(sel_n), .mem_rd(mem_rd), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .dout(dout), .dout_en(dout_en));

    function automatic logic arr_bit(input int b, input int a);
        logic [21:0] k;
        k = {b[1:0], a[19:0]};
        return (^(k & 22'h2D6B39)) ^ (b == 1);
    endfunction

    // Behavioural storage array: one-clock read latency.
    always @(posedge clk) if (mem_rd) mem_rdata <= arr_bit(int'(mem_bank), int'(mem_addr));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Two-clock delayed view of read clock and selects, for the enable check (R7).
    always @(posedge clk) begin
        h1 <= {sel_n, rd_clk};
        h2 <= h1;
        if (rst_n) settle <= settle + 1;
    end
    always @(negedge clk) if (rst_n && settle > 3)
        chk("R7 enable", int'(dout_en), int'((h2[3:1] != 3'b111) && !h2[0]));

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input bit is_y, input int val, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            if (is_y) sy_dat = val[i]; else sx_dat = val[i];
            waitn(3);
            if (is_y) sy_strb = 0; else sx_strb = 0;
            waitn(3);
            if (is_y) sy_strb = 1; else sx_strb = 1;
            waitn(3);
        end
    endtask

    task automatic xfer();
        xfer_strb = 0; waitn(4); xfer_strb = 1; waitn(4);
    endtask

    task automatic set_sel(input logic [2:0] s, input int b);
        sel_n = s; cur_bank = b; waitn(4);
    endtask

    task automatic do_read(input string tag);
        logic exp;
        exp = arr_bit(cur_bank, model_addr);
        rd_clk = 0; waitn(6);
        model_addr = (model_addr + 1) & 32'hFFFFF;
        chk({tag, " R8 dout"}, int'(dout), int'(exp));
        chk({tag, " R5 advance"}, int'(mem_addr), model_addr);
        waitn(5);
        chk({tag, " R7 hold"}, int'(dout), int'(exp));
        rd_clk = 1; waitn(4);
    endtask

    initial begin
        fork
            begin
                repeat (190000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual hung expected done");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none

        waitn(5); rst_n = 1; waitn(3);
        chk("R4 reset addr", int'(mem_addr), 0);
        chk("R7 reset en", int'(dout_en), 0);
        chk("R8 reset dout", int'(dout), 0);

        // R1 R2 R4: load a start address and stream bits.
        set_sel(3'b110, 0);
        send(0, 'h2A5, 10);
        send(1, 'h13C, 10);
        xfer();
        model_addr = ('h13C << 10) | 'h2A5;
        chk("R1 R2 R4 load", int'(mem_addr), model_addr);
        do_read("R5a"); do_read("R5b"); do_read("R5c");

        // R3: extra bits are pushed out; Y keeps its contents (R2).
        send(0, 'h7, 3);
        send(0, 'h0C9, 10);
        xfer();
        model_addr = ('h13C << 10) | 'h0C9;
        chk("R3 last ten bits", int'(mem_addr), model_addr);

        // R5 carry from X into Y.
        send(0, 'h3FF, 10); send(1, 'h005, 10); xfer();
        model_addr = 'h017FF;
        do_read("R5 carry");
        chk("R5 carry addr", int'(mem_addr), 'h01800);

        // R6 full wrap.
        send(1, 'h3FF, 10); xfer();
        model_addr = 'hFFFFF;
        do_read("R6 wrap");
        chk("R6 zero", int'(mem_addr), 0);

        // R9 bank decode and priority; R11 address untouched by select changes.
        set_sel(3'b101, 1); chk("R9 bank2", int'(mem_bank), 1);
        chk("R11 keep addr", int'(mem_addr), model_addr);
        do_read("R9 b2");
        set_sel(3'b011, 2); chk("R9 bank3", int'(mem_bank), 2);
        do_read("R9 b3");
        set_sel(3'b000, 0); chk("R9 prio all", int'(mem_bank), 0);
        set_sel(3'b001, 1); chk("R9 prio 2v3", int'(mem_bank), 1);
        chk("R11 keep addr2", int'(mem_addr), model_addr);

        // R10: nothing changes while deselected.
        set_sel(3'b111, 0);
        rd_clk = 0; waitn(6);
        chk("R10 en off", int'(dout_en), 0);
        rd_clk = 1; waitn(4);
        send(0, 'h0AA, 10); send(1, 'h055, 10); xfer();
        set_sel(3'b110, 0);
        chk("R10 counter kept", int'(mem_addr), model_addr);
        do_read("R10 read");
        xfer();
        model_addr = 'hFFFFF;
        chk("R10 sregs kept", int'(mem_addr), model_addr);

        waitn(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule